// File: doc/BRIEF.md
# Interrupt priority level sampler

This block turns a three-pin, active-low interrupt priority request into a clean pending-interrupt indication. It samples the pins on every rising clock edge and accepts a level only when two consecutive samples agree. An accepted level is compared against a three-bit mask. The mask holds the highest level that is ignored, so the level must be strictly above the mask to pass. A passing level is latched as pending, together with its priority.

The pending state is held even if the request goes away. A later, higher validated level replaces the one that is pending. The state is cleared only when the surrounding bus logic reports that an acknowledge cycle has finished for the pending level. That acknowledge is the bus cycle whose transfer type code is 3. The exception sequencer that consumes the pending flag is outside this block.

Top module: `irq_level_sampler`

## Requirements
- R1: While `rst` is high at a rising edge, the sample registers and the pending state are cleared: `irq_pend` is 0 and `irq_pend_lvl` is 0 after that edge.
- R2: The requested level is the bitwise inverse of `irq_req_n`, so pins 3'b010 request level 5.
- R3: A level is validated only when two consecutive samples are equal. A request applied before edge k shows as pending after edge k+2, and not after edge k+1.
- R4: A validated level becomes pending only when it is strictly greater than `irq_mask`. A level equal to or below the mask leaves `irq_pend` at 0.
- R5: Level 0 (pins 3'b111) never becomes pending, whatever the mask is.
- R6: Level 7 becomes pending even when `irq_mask` is 7.
- R7: A request held for only two sampling edges is latched as pending, and it stays pending after the pins return to 3'b111.
- R8: While a level is pending, a higher validated, unmasked level replaces `irq_pend_lvl` one edge after it validates. A lower one leaves the pending level unchanged.
- R9: `ack_done` high at an edge with `ack_lvl` equal to `irq_pend_lvl` clears `irq_pend` and `irq_pend_lvl` to 0 after that edge, provided no new request is qualifying.
- R10: `ack_done` with `ack_lvl` different from the pending level has no effect on the pending state.
- R11: A request present for only one sampling edge never becomes pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| irq_req_n | input | 3 | Active-low priority request pins |
| irq_mask | input | 3 | Highest ignored priority level |
| ack_done | input | 1 | Pulse when an interrupt acknowledge cycle (transfer type 3) completes |
| ack_lvl | input | 3 | Level that the completed acknowledge served |
| irq_pend | output | 1 | An interrupt is pending |
| irq_pend_lvl | output | 3 | Level of the pending interrupt, 0 when none |

## Verification
A fault in the two sample registers shows up as a shift in when `irq_pend` rises. The flag may rise one edge early, or a one-edge glitch may get through. Either effect appears within three edges of the pin change. A fault in the pending register shows up the same way: a wrong `irq_pend_lvl`, a lost raise, or a clear that an unrelated acknowledge should not cause. This appears one edge after the validating sample or the acknowledge. So every scenario checks the outputs at the exact edge where they must change, and also at the edge just before it.

// File: rtl/irq_lvl_pkg.sv
package irq_lvl_pkg;
  localparam int LVL_W = 3;
  localparam logic [LVL_W-1:0] LVL_TOP = {LVL_W{1'b1}};
  typedef logic [LVL_W-1:0] lvl_t;

  // Active-low pins to priority level.
  function automatic lvl_t pins_to_level(input lvl_t pins_n);
    return ~pins_n;
  endfunction

  // Level qualifies against the mask: nonzero and above the mask, top level unmaskable.
  function automatic logic level_passes(input lvl_t lvl, input lvl_t msk);
    return (lvl != '0) && ((lvl == LVL_TOP) || (lvl > msk));
  endfunction
endpackage

// File: rtl/irq_sync_filter.sv
module irq_sync_filter
  import irq_lvl_pkg::*;
#(
  parameter int W = LVL_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pins_n,
  output logic         stable,
  output logic [W-1:0] level
);
  logic [W-1:0] smp_now;
  logic [W-1:0] smp_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      smp_now  <= '0;
      smp_prev <= '0;
    end else begin
      smp_now  <= pins_to_level(pins_n);
      smp_prev <= smp_now;
    end
  end

  assign stable = (smp_now == smp_prev);
  assign level  = smp_now;

  // R11: a level seen stable must have been present on the previous sampling edge as well
  assert_two_samples_R11: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && stable && level != '0) |-> ($past(level) == level));
endmodule

// File: rtl/irq_pend_track.sv
module irq_pend_track
  import irq_lvl_pkg::*;
#(
  parameter int W = LVL_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         lvl_ok,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] mask,
  input  logic         ack_done,
  input  logic [W-1:0] ack_lvl,
  output logic         pend,
  output logic [W-1:0] pend_lvl
);
  logic take_new;
  logic ack_hit;
  logic qualifies;

  assign qualifies = lvl_ok && level_passes(lvl, mask);
  assign take_new  = qualifies && (!pend || (lvl > pend_lvl));
  assign ack_hit   = ack_done && pend && (ack_lvl == pend_lvl);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend     <= 1'b0;
      pend_lvl <= '0;
    end else if (take_new) begin
      pend     <= 1'b1;
      pend_lvl <= lvl;
    end else if (ack_hit) begin
      pend     <= 1'b0;
      pend_lvl <= '0;
    end
  end

  assert_lvl_nonzero_R5: assert property (@(posedge clk) disable iff (rst)
    pend |-> (pend_lvl != '0));
  assert_idle_lvl_R1: assert property (@(posedge clk) disable iff (rst)
    !pend |-> (pend_lvl == '0));
  assert_capture_R4: assert property (@(posedge clk) disable iff (rst)
    (qualifies && !pend) |=> (pend && pend_lvl == $past(lvl)));
  assert_raise_R8: assert property (@(posedge clk) disable iff (rst)
    (pend && qualifies && lvl > pend_lvl) |=> (pend_lvl == $past(lvl)));
  assert_ack_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (ack_hit && !qualifies) |=> !pend);
  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (pend && !ack_hit && !take_new) |=> (pend && $stable(pend_lvl)));
  assert_no_spurious_R4: assert property (@(posedge clk) disable iff (rst)
    (!pend && !qualifies) |=> !pend);
endmodule

// File: rtl/irq_level_sampler.sv
module irq_level_sampler
  import irq_lvl_pkg::*;
#(
  parameter int W = LVL_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] irq_req_n,
  input  logic [W-1:0] irq_mask,
  input  logic         ack_done,
  input  logic [W-1:0] ack_lvl,
  output logic         irq_pend,
  output logic [W-1:0] irq_pend_lvl
);
  logic         lvl_stable;
  logic [W-1:0] lvl_seen;

  irq_sync_filter #(.W(W)) u_filt (
    .clk    (clk),
    .rst    (rst),
    .pins_n (irq_req_n),
    .stable (lvl_stable),
    .level  (lvl_seen)
  );

  irq_pend_track #(.W(W)) u_track (
    .clk      (clk),
    .rst      (rst),
    .lvl_ok   (lvl_stable),
    .lvl      (lvl_seen),
    .mask     (irq_mask),
    .ack_done (ack_done),
    .ack_lvl  (ack_lvl),
    .pend     (irq_pend),
    .pend_lvl (irq_pend_lvl)
  );

  // R6: the top level is pending one edge after it validates, whatever the mask
  assert_top_level_R6: assert property (@(posedge clk) disable iff (rst)
    (lvl_stable && lvl_seen == LVL_TOP) |=> (irq_pend && irq_pend_lvl == LVL_TOP));
endmodule

// File: tb/sim_irq_level_sampler.sv
module sim_irq_level_sampler;
  logic       clk = 1'b0;
  logic       rst;
  logic [2:0] irq_req_n;
  logic [2:0] irq_mask;
  logic       ack_done;
  logic [2:0] ack_lvl;
  logic       irq_pend;
  logic [2:0] irq_pend_lvl;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  irq_level_sampler u0 (
    .clk(clk), .rst(rst), .irq_req_n(irq_req_n), .irq_mask(irq_mask),
    .ack_done(ack_done), .ack_lvl(ack_lvl),
    .irq_pend(irq_pend), .irq_pend_lvl(irq_pend_lvl)
  );

  task automatic chk(input string req, input logic exp_p, input logic [2:0] exp_l);
    checks++;
    if (irq_pend !== exp_p || irq_pend_lvl !== exp_l) begin
      fails++;
      $display("FAIL %s: got pend=%0b lvl=%0d, expected pend=%0b lvl=%0d",
               req, irq_pend, irq_pend_lvl, exp_p, exp_l);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic request(input logic [2:0] lvl);
    irq_req_n = ~lvl;
  endtask

  task automatic do_reset();
    rst = 1'b1; irq_req_n = 3'b111; irq_mask = 3'd0; ack_done = 1'b0; ack_lvl = 3'd0;
    cyc(2);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 reset state", 1'b0, 3'd0);
  endtask

  task automatic t_decode_latency();
    do_reset();
    request(3'd5);   // pins 3'b010 mean level 5 (R2)
    cyc(2);
    chk("R3 not pending after second edge", 1'b0, 3'd0);
    cyc(1);
    chk("R2 R3 level 5 pending after third edge", 1'b1, 3'd5);
  endtask

  task automatic t_glitch();
    do_reset();
    request(3'd6);
    cyc(1);
    request(3'd0);
    cyc(4);
    chk("R11 one-edge glitch ignored", 1'b0, 3'd0);
  endtask

  task automatic t_mask();
    do_reset();
    irq_mask = 3'd4;
    request(3'd4);
    cyc(5);
    chk("R4 level equal to mask ignored", 1'b0, 3'd0);
    request(3'd2);
    cyc(5);
    chk("R4 level below mask ignored", 1'b0, 3'd0);
    request(3'd5);
    cyc(3);
    chk("R4 level above mask pends", 1'b1, 3'd5);
  endtask

  task automatic t_zero();
    do_reset();
    irq_mask = 3'd0;
    request(3'd0);
    cyc(5);
    chk("R5 level 0 never pends", 1'b0, 3'd0);
  endtask

  task automatic t_nmi();
    do_reset();
    irq_mask = 3'd7;
    request(3'd6);
    cyc(5);
    chk("R4 level 6 masked by 7", 1'b0, 3'd0);
    request(3'd7);
    cyc(3);
    chk("R6 level 7 pends with mask 7", 1'b1, 3'd7);
  endtask

  task automatic t_pulse();
    do_reset();
    irq_mask = 3'd1;
    request(3'd3);
    cyc(2);
    request(3'd0);
    cyc(1);
    chk("R7 two-edge pulse latched", 1'b1, 3'd3);
    cyc(5);
    chk("R7 pending held after release", 1'b1, 3'd3);
  endtask

  task automatic t_raise();
    do_reset();
    request(3'd3);
    cyc(3);
    chk("R8 base level pending", 1'b1, 3'd3);
    request(3'd5);
    cyc(2);
    chk("R8 not raised before validation", 1'b1, 3'd3);
    cyc(1);
    chk("R8 raised to higher level", 1'b1, 3'd5);
    request(3'd2);
    cyc(5);
    chk("R8 lower level leaves pending", 1'b1, 3'd5);
  endtask

  task automatic t_ack();
    do_reset();
    request(3'd4);
    cyc(2);
    request(3'd0);
    cyc(4);
    chk("R9 pending before ack", 1'b1, 3'd4);
    ack_done = 1'b1; ack_lvl = 3'd2;
    cyc(1);
    ack_done = 1'b0;
    chk("R10 ack for other level ignored", 1'b1, 3'd4);
    ack_done = 1'b1; ack_lvl = 3'd4;
    cyc(1);
    ack_done = 1'b0;
    chk("R9 matching ack clears", 1'b0, 3'd0);
    cyc(3);
    chk("R9 stays clear", 1'b0, 3'd0);
  endtask

  task automatic t_reset_mid();
    request(3'd6);
    cyc(3);
    chk("R1 pending before reset", 1'b1, 3'd6);
    rst = 1'b1;
    cyc(1);
    chk("R1 reset clears pending", 1'b0, 3'd0);
    rst = 1'b0;
    cyc(2);
    chk("R1 R3 samples cleared, re-validation needed", 1'b0, 3'd0);
    cyc(1);
    chk("R3 pends again after validation", 1'b1, 3'd6);
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; irq_req_n = 3'b111; irq_mask = 3'd0; ack_done = 1'b0; ack_lvl = 3'd0;
    @(negedge clk);
    t_reset();
    t_decode_latency();
    t_glitch();
    t_mask();
    t_zero();
    t_nmi();
    t_pulse();
    t_raise();
    t_ack();
    t_reset_mid();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule